// File: doc/BRIEF.md
# Shifted-Operand ALU with Condition Flags

This block performs one 32-bit data-processing operation per accepted request. The second operand always goes through a barrel shifter first. The shifter can do a logical left shift, a logical right shift, an arithmetic right shift, a rotate right, or a one-bit rotate through the incoming carry. The shifted value then meets the first operand in one of ten operations: plain add, add with carry, subtract, subtract with carry, reverse subtract, AND, OR, OR-NOT, exclusive OR, and bit clear (first operand AND NOT second).

Each request carries its own incoming N, Z, C and V flags, so no request depends on an earlier one. The block returns the 32-bit result and the next flag value. The new flags replace the incoming ones only when the request's set-flags bit is high; otherwise the incoming flags pass through unchanged. Wide-immediate adds and plain ORs that must not touch the flags are issued with set-flags low.

Requests enter on a valid/ready port and results leave on a valid/ready port through a single output register. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented, with `out_valid` high, from the next cycle on. While `out_valid` is high and `out_ready` is low, the output is frozen and `in_ready` is low. With `out_ready` held high, one request is accepted every cycle.

Top module: `shift_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `result` is 0 and `flags_out` is 0; after release, `in_ready` is 1.
- R2: `in_ready` is high exactly when the output register is empty or `out_ready` is high. An accepted request appears on `result`/`flags_out` with `out_valid` high in the following cycle.
- R3: While `out_valid` is high and `out_ready` is low, `result`, `flags_out` and `out_valid` hold their values and no new request is taken.
- R4: Shift kind 0 shifts left and kind 1 shifts right, both logically. For amounts 1..32 the carry-out is the last bit shifted out. Amounts above 32 give a value of 0 and a carry-out of 0.
- R5: Shift kind 2 is an arithmetic right shift. Amounts of 32 or more fill every bit with the sign bit, and the carry-out is then the sign bit.
- R6: Shift kind 3 rotates right by the amount modulo 32, with a nonzero amount giving a carry-out equal to result bit 31 (rotating 0x1048B3C5 by 24 gives 0x48B3C510). Kind 4 ignores the amount, shifts right by one, moves incoming C into bit 31 and puts the old bit 0 in the carry-out.
- R7: For kinds 0 to 3 an amount of 0 leaves the operand unchanged, and the shifter carry-out equals incoming C.
- R8: The opcode (`alu_op`) selects the arithmetic:
  - 0: A+B
  - 1: A+B+C
  - 2: A−B
  - 3: A−B−(1−C)
  - 4: B−A

  Here B is the shifted operand and C is the incoming carry flag.
- R9: Opcodes select the logic function: 5 AND, 6 OR, 7 A OR NOT B, 8 XOR, 9 A AND NOT B.
- R10: `flags_in`/`flags_out` bit order is N[3], Z[2], C[1], V[0]. For arithmetic with set-flags high:
  - N is result bit 31.
  - Z is set when the result is zero.
  - C is the carry out of bit 31; for subtraction this means 1 = no borrow.
  - V is signed overflow.
- R11: For logic opcodes with set-flags high, N and Z follow the result, C is the shifter carry-out, and V is kept from `flags_in`.
- R12: With `set_flags` low, `flags_out` equals the request's `flags_in` for every opcode.
- R13: Opcodes 10..15 give a result of 0 and leave the flags unchanged. Shift kinds 5..7 pass the operand through unchanged with a carry-out equal to incoming C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Operand routed through the shifter |
| alu_op | input | 4 | Operation code (R8, R9, R13) |
| sh_kind | input | 3 | Shift kind (R4–R7, R13) |
| sh_amt | input | 6 | Shift amount 0..63 |
| set_flags | input | 1 | Write computed flags when high |
| flags_in | input | 4 | Incoming N, Z, C, V |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| result | output | 32 | Operation result |
| flags_out | output | 4 | Next N, Z, C, V |

## Verification
The only state is the output register, so a fault there shows up within one cycle of the accept. Possible symptoms are:
- a result from the wrong request;
- a value that drifts while the output is stalled;
- a flag nibble that ignores `set_flags`.

A wrong shifter carry or a wrong overflow rule shows up only in `flags_out`, and only on flag-setting requests. The directed cases therefore pin the shift amounts 0, 32 and above 32, plus the signed-overflow and equal-operand subtractions.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned FLAG_W = 4;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBC = 4'd3;
  localparam logic [3:0] OP_RSB = 4'd4;
  localparam logic [3:0] OP_AND = 4'd5;
  localparam logic [3:0] OP_ORR = 4'd6;
  localparam logic [3:0] OP_ORN = 4'd7;
  localparam logic [3:0] OP_EOR = 4'd8;
  localparam logic [3:0] OP_BIC = 4'd9;

  localparam logic [2:0] SH_LSL = 3'd0;
  localparam logic [2:0] SH_LSR = 3'd1;
  localparam logic [2:0] SH_ASR = 3'd2;
  localparam logic [2:0] SH_ROR = 3'd3;
  localparam logic [2:0] SH_RRX = 3'd4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/barrel_shift.sv
module barrel_shift
  import alu_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned AMT_W = $clog2(W) + 1
) (
  input  logic [W-1:0]     x,
  input  logic [2:0]       kind,
  input  logic [AMT_W-1:0] amt,
  input  logic             cin,
  output logic [W-1:0]     y,
  output logic             cout
);
  localparam int unsigned RW = $clog2(W);

  // one guard bit beside the operand catches the last bit shifted out
  logic [W:0]        lsl_t;
  logic [W:0]        lsr_t;
  logic signed [W:0] asr_t;
  logic [RW-1:0]     rot_n;
  logic [AMT_W-1:0]  rot_l;
  logic [W-1:0]      rot_v;
  logic              amt_zero;

  assign amt_zero = (amt == '0);
  assign lsl_t    = {1'b0, x} << amt;
  assign lsr_t    = {x, 1'b0} >> amt;
  assign asr_t    = $signed({x, 1'b0}) >>> amt;
  assign rot_n    = amt[RW-1:0];
  assign rot_l    = AMT_W'(W) - {{(AMT_W-RW){1'b0}}, rot_n};
  assign rot_v    = (x >> rot_n) | (x << rot_l);

  always_comb begin
    y    = x;
    cout = cin;
    case (kind)
      SH_LSL: begin
        y    = lsl_t[W-1:0];
        cout = amt_zero ? cin : lsl_t[W];
      end
      SH_LSR: begin
        y    = lsr_t[W:1];
        cout = amt_zero ? cin : lsr_t[0];
      end
      SH_ASR: begin
        y    = asr_t[W:1];
        cout = amt_zero ? cin : asr_t[0];
      end
      SH_ROR: begin
        y    = rot_v;
        cout = amt_zero ? cin : rot_v[W-1];
      end
      SH_RRX: begin
        y    = {cin, x[W-1:1]};
        cout = x[0];
      end
      default: begin
        y    = x;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         sh_c,
  input  logic         set_flags,
  input  flags_t       fin,
  output logic [W-1:0] res,
  output flags_t       fnext
);
  localparam int unsigned SW = W + 1;

  logic [W-1:0]  ax, bx, lres;
  logic          ci, arith, known, ovf;
  logic [SW-1:0] sum;

  always_comb begin
    ax    = a;
    bx    = b;
    ci    = 1'b0;
    arith = 1'b0;
    known = 1'b1;
    lres  = '0;
    case (op)
      OP_ADD: arith = 1'b1;
      OP_ADC: begin arith = 1'b1; ci = fin.c; end
      OP_SUB: begin arith = 1'b1; bx = ~b; ci = 1'b1; end
      OP_SBC: begin arith = 1'b1; bx = ~b; ci = fin.c; end
      OP_RSB: begin arith = 1'b1; ax = b; bx = ~a; ci = 1'b1; end
      OP_AND: lres = a & b;
      OP_ORR: lres = a | b;
      OP_ORN: lres = a | ~b;
      OP_EOR: lres = a ^ b;
      OP_BIC: lres = a & ~b;
      default: known = 1'b0;
    endcase
  end

  // a single adder serves all five arithmetic forms via operand inversion
  assign sum = {1'b0, ax} + {1'b0, bx} + {{W{1'b0}}, ci};
  assign ovf = (ax[W-1] == bx[W-1]) && (sum[W-1] != ax[W-1]);
  assign res = !known ? '0 : (arith ? sum[W-1:0] : lres);

  always_comb begin
    fnext = fin;
    if (set_flags && known) begin
      fnext.n = res[W-1];
      fnext.z = (res == '0);
      fnext.c = arith ? sum[W] : sh_c;
      fnext.v = arith ? ovf : fin.v;
    end
  end
endmodule

// File: rtl/hold_stage.sv
module hold_stage #(
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          vld_q;
  logic [DW-1:0] data_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      vld_q  <= 1'b1;
      data_q <= in_data;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/shift_alu.sv
module shift_alu
  import alu_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned AMT_W = $clog2(W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [3:0]       alu_op,
  input  logic [2:0]       sh_kind,
  input  logic [AMT_W-1:0] sh_amt,
  input  logic             set_flags,
  input  logic [3:0]       flags_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     result,
  output logic [3:0]       flags_out
);
  localparam int unsigned PW = W + FLAG_W;

  flags_t        fin, fnx;
  logic [W-1:0]  sh_val, alu_res;
  logic          sh_cy;
  logic [PW-1:0] hold_q;

  assign fin = flags_t'(flags_in);

  barrel_shift #(.W(W), .AMT_W(AMT_W)) u_shift (
    .x    (op_b),
    .kind (sh_kind),
    .amt  (sh_amt),
    .cin  (fin.c),
    .y    (sh_val),
    .cout (sh_cy)
  );

  alu_core #(.W(W)) u_core (
    .a         (op_a),
    .b         (sh_val),
    .op        (alu_op),
    .sh_c      (sh_cy),
    .set_flags (set_flags),
    .fin       (fin),
    .res       (alu_res),
    .fnext     (fnx)
  );

  hold_stage #(.DW(PW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({fnx, alu_res}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (hold_q)
  );

  assign flags_out = hold_q[PW-1:W];
  assign result    = hold_q[W-1:0];
endmodule

// File: rtl/shift_alu_chk.sv
module shift_alu_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [3:0]   alu_op,
  input logic         set_flags,
  input logic [3:0]   flags_in,
  input logic [W-1:0] result,
  input logic [3:0]   flags_out
);
  a_r2_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(flags_out)));

  a_r3_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r10_nz_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && set_flags && alu_op < 4'd10)
      |=> (flags_out[3] == result[W-1] && flags_out[2] == (result == '0)));

  a_r11_v_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && set_flags && alu_op >= 4'd5 && alu_op <= 4'd9)
      |=> (flags_out[0] == $past(flags_in[0])));

  a_r12_flags_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !set_flags) |=> (flags_out == $past(flags_in)));

  a_r13_reserved_op: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && alu_op >= 4'd10)
      |=> (result == '0 && flags_out == $past(flags_in)));
endmodule

bind shift_alu shift_alu_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .alu_op    (alu_op),
  .set_flags (set_flags),
  .flags_in  (flags_in),
  .result    (result),
  .flags_out (flags_out)
);

// File: tb/tb_shift_alu.sv
`timescale 1ns/1ps
module tb_shift_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0, op_b = '0;
  logic [3:0]  alu_op = '0;
  logic [2:0]  sh_kind = '0;
  logic [5:0]  sh_amt = '0;
  logic        set_flags = 1'b0;
  logic [3:0]  flags_in = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] result;
  logic [3:0]  flags_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shift_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .alu_op(alu_op), .sh_kind(sh_kind),
    .sh_amt(sh_amt), .set_flags(set_flags), .flags_in(flags_in),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .flags_out(flags_out)
  );

  // bit-serial reference shifter: returns {carry, value}
  function automatic logic [32:0] m_shift(input logic [31:0] x, input logic [2:0] k,
                                          input logic [5:0] n, input logic c);
    logic [31:0] v = x;
    logic        cy = c;
    case (k)
      3'd0: for (int i = 0; i < n; i++) begin cy = v[31]; v = v << 1; end
      3'd1: for (int i = 0; i < n; i++) begin cy = v[0]; v = v >> 1; end
      3'd2: for (int i = 0; i < n; i++) begin cy = v[0]; v = {v[31], v[31:1]}; end
      3'd3: for (int i = 0; i < n; i++) begin cy = v[0]; v = {v[0], v[31:1]}; end
      3'd4: begin cy = v[0]; v = {c, v[31:1]}; end
      default: ;
    endcase
    return {cy, v};
  endfunction

  function automatic bit sovf(input longint s);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  // reference operation: returns {N,Z,C,V, result}
  function automatic logic [35:0] m_alu(input logic [31:0] a, input logic [31:0] x,
                                        input logic [3:0] op, input logic [2:0] k,
                                        input logic [5:0] n, input logic sf,
                                        input logic [3:0] fl);
    logic [32:0] sh = m_shift(x, k, n, fl[1]);
    logic [31:0] b = sh[31:0];
    logic [63:0] ua = {32'd0, a};
    logic [63:0] ub = {32'd0, b};
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    logic [63:0] br = {63'd0, ~fl[1]};
    logic [31:0] r = '0;
    logic c = fl[1];
    logic v = fl[0];
    bit arith = 1'b1;
    bit known = 1'b1;
    logic [63:0] t;
    case (op)
      4'd0: begin t = ua + ub; r = t[31:0]; c = t[32]; v = sovf(sa + sb); end
      4'd1: begin t = ua + ub + {63'd0, fl[1]}; r = t[31:0]; c = t[32];
                  v = sovf(sa + sb + longint'(fl[1])); end
      4'd2: begin t = ua - ub; r = t[31:0]; c = (ua >= ub); v = sovf(sa - sb); end
      4'd3: begin t = ua - ub - br; r = t[31:0]; c = (ua >= ub + br);
                  v = sovf(sa - sb - longint'(br)); end
      4'd4: begin t = ub - ua; r = t[31:0]; c = (ub >= ua); v = sovf(sb - sa); end
      4'd5: begin arith = 0; r = a & b; end
      4'd6: begin arith = 0; r = a | b; end
      4'd7: begin arith = 0; r = a | ~b; end
      4'd8: begin arith = 0; r = a ^ b; end
      4'd9: begin arith = 0; r = a & ~b; end
      default: begin known = 0; r = '0; end
    endcase
    if (!known || !sf) return {fl, r};
    if (!arith) begin c = sh[32]; v = fl[0]; end
    return {r[31], (r == 32'd0), c, v, r};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] a, input logic [31:0] b,
                     input logic [3:0] op, input logic [2:0] k, input logic [5:0] n,
                     input logic sf, input logic [3:0] fl);
    logic [35:0] e;
    @(negedge clk);
    op_a = a; op_b = b; alu_op = op; sh_kind = k; sh_amt = n;
    set_flags = sf; flags_in = fl; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = m_alu(a, b, op, k, n, sf, fl);
    check(tag, {27'd0, out_valid, flags_out, result}, {27'd0, 1'b1, e});
  endtask

  initial begin
    #(10 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: got hang expected finish");
    if (!done) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [35:0] ea;
    void'($urandom(32'd20240611));
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {27'd0, out_valid, flags_out, result}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {63'd0, in_ready}, 64'd1);

    // worked vectors, incoming flags NZCV = 0010
    run("R6 ror24 value", 32'h0, 32'h1048B3C5, 4'd6, 3'd3, 6'd24, 1'b0, 4'b0010);
    check("R6 rotate literal", {32'd0, result}, {32'd0, 32'h48B3C510});
    run("R6 R8 R10 adc ror", 32'h7F0E0C2D, 32'h1048B3C5, 4'd1, 3'd3, 6'd24, 1'b1, 4'b0010);
    check("R8 adc literal", {32'd0, result}, {32'd0, 32'hC7C1D13E});
    run("R12 wide add", 32'h2468ACE0, 32'h00000F1B, 4'd0, 3'd0, 6'd0, 1'b0, 4'b0010);
    run("R8 R10 sub", 32'h2468ACE0, 32'h1048B3C5, 4'd2, 3'd0, 6'd0, 1'b1, 4'b0010);
    run("R8 R10 rsb", 32'h2468ACE0, 32'h00000012, 4'd4, 3'd0, 6'd0, 1'b1, 4'b0010);
    run("R4 R8 R10 sbc lsl", 32'h7F0E0C2D, 32'h1048B3C5, 4'd3, 3'd0, 6'd12, 1'b1, 4'b0010);
    run("R4 R9 R11 eor lsr", 32'h2468ACE0, 32'h1048B3C5, 4'd8, 3'd1, 6'd4, 1'b1, 4'b0010);
    run("R6 R9 R11 bic rrx", 32'h2468ACE0, 32'h1048B3C5, 4'd9, 3'd4, 6'd17, 1'b1, 4'b0010);
    run("R5 R9 R11 and asr", 32'h7F0E0C2D, 32'h2468ACE0, 4'd5, 3'd2, 6'd28, 1'b1, 4'b0010);
    run("R9 R12 orr", 32'h2468ACE0, 32'h1048B3C5, 4'd6, 3'd0, 6'd0, 1'b0, 4'b0010);
    run("R9 R11 orn imm", 32'h2468ACE0, 32'hB600B600, 4'd7, 3'd0, 6'd0, 1'b1, 4'b0010);

    // shifter boundaries through ORR with zero, flags set
    run("R4 lsl 32", 32'h0, 32'h80000001, 4'd6, 3'd0, 6'd32, 1'b1, 4'b0001);
    check("R4 lsl 32 flags", {60'd0, flags_out}, {60'd0, 4'b0111});
    run("R4 lsl 40", 32'h0, 32'hFFFFFFFF, 4'd6, 3'd0, 6'd40, 1'b1, 4'b0010);
    check("R4 lsl 40 flags", {60'd0, flags_out}, {60'd0, 4'b0100});
    run("R4 lsr 32", 32'h0, 32'h80000000, 4'd6, 3'd1, 6'd32, 1'b1, 4'b0000);
    run("R5 asr 40", 32'h0, 32'h80000000, 4'd6, 3'd2, 6'd40, 1'b1, 4'b0000);
    check("R5 asr fill", {28'd0, flags_out, result}, {28'd0, 4'b1010, 32'hFFFFFFFF});
    run("R6 ror 36", 32'h0, 32'h1234567F, 4'd6, 3'd3, 6'd36, 1'b1, 4'b0000);
    run("R6 ror 32", 32'h0, 32'h80000000, 4'd6, 3'd3, 6'd32, 1'b1, 4'b0000);
    run("R7 amt0 c1", 32'h0, 32'h00000001, 4'd6, 3'd1, 6'd0, 1'b1, 4'b0010);
    check("R7 amt0 keeps C", {60'd0, flags_out}, {60'd0, 4'b0010});
    run("R7 amt0 c0", 32'h0, 32'h80000000, 4'd6, 3'd0, 6'd0, 1'b1, 4'b0000);
    run("R10 sub equal", 32'h55AA55AA, 32'h55AA55AA, 4'd2, 3'd0, 6'd0, 1'b1, 4'b0000);
    check("R10 equal flags", {60'd0, flags_out}, {60'd0, 4'b0110});
    run("R10 add overflow", 32'h7FFFFFFF, 32'h1, 4'd0, 3'd0, 6'd0, 1'b1, 4'b0000);
    check("R10 ovf flags", {60'd0, flags_out}, {60'd0, 4'b1001});
    run("R8 sbc borrow", 32'h0, 32'h0, 4'd3, 3'd0, 6'd0, 1'b1, 4'b0000);
    run("R13 reserved op", 32'hFFFF0000, 32'h1234, 4'd12, 3'd0, 6'd3, 1'b1, 4'b1011);
    check("R13 reserved literal", {28'd0, flags_out, result}, {28'd0, 4'b1011, 32'd0});
    run("R13 reserved kind", 32'h0, 32'hC0000003, 4'd6, 3'd6, 6'd9, 1'b1, 4'b0010);

    // R2 R3 back-pressure
    @(negedge clk);
    op_a = 32'd10; op_b = 32'd5; alu_op = 4'd0; sh_kind = 3'd0; sh_amt = 6'd0;
    set_flags = 1'b1; flags_in = 4'b0000; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R2 ready low when full", {63'd0, in_ready}, 64'd0);
    op_a = 32'd99; op_b = 32'd1;
    repeat (3) @(negedge clk);
    check("R3 held output", {27'd0, out_valid, flags_out, result}, {27'd0, 1'b1, 4'b0000, 32'd15});
    out_ready = 1'b1;
    #1;
    check("R2 ready with out_ready", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    ea = m_alu(32'd99, 32'd1, 4'd0, 3'd0, 6'd0, 1'b1, 4'b0000);
    check("R2 next after stall", {27'd0, out_valid, flags_out, result}, {27'd0, 1'b1, ea});
    @(negedge clk);
    check("R2 drains", {63'd0, out_valid}, 64'd0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      logic [3:0]  rop;
      logic [2:0]  rk;
      logic [5:0]  rn;
      logic        rsf;
      logic [3:0]  rfl;
      string       tg;
      ra  = $urandom();
      rb  = ($urandom_range(0, 15) == 0) ? ra : $urandom();
      rop = 4'($urandom_range(0, 15));
      rk  = 3'($urandom_range(0, 7));
      rn  = 6'($urandom_range(0, 63));
      rsf = ($urandom_range(0, 3) != 0);
      rfl = 4'($urandom());
      if (rop > 4'd9) tg = "R13 random";
      else if (!rsf) tg = "R12 random";
      else if (rop < 4'd5) tg = "R8 R10 random";
      else tg = "R9 R11 random";
      run(tg, ra, rb, rop, rk, rn, rsf, rfl);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule